// File: doc/BRIEF.md
# Open-Drain Pin Pair Control Register

This block is a small control register that gives software direct command of two pad pins, a clock pin and a data pin, so that an I2C bus can be driven by toggling bits from software. Each pin is held in one of four states formed by a direction bit and an output value bit. A pin whose direction is input is released, and the external pull-up takes it high. A pin whose direction is output with value 0 pulls the line low. Together these give open-drain behaviour without any pad support for it.

Every write carries strobe bits next to the direction and value fields. A field changes only when its strobe is set in that same write. Software can therefore flip one pin's direction, or load its value, with a single write and no read-modify-write. The strobes are not stored and read back as zero. The live pad level of each pin passes through a two-flop synchroniser into a read-only field. Each pin also has a plain read/write pull-up-disable bit, which software writes back on every access.

Each pin's controller is a four-state machine. The states are FLOAT_LO (input, value 0), FLOAT_HI (input, value 1), SINK (output, value 0, the pin driven low) and SOURCE (output, value 1). Write transitions are named by the strobes they carry. HOLD has no strobe, or no write at all, and keeps the state. LOAD_VAL takes the value strobe only: it keeps the direction and takes the value. LOAD_DIR takes the direction strobe only: it keeps the value and takes the direction. LOAD_BOTH takes both strobes and both fields. In terms of these, RELEASE is LOAD_DIR or LOAD_BOTH with direction 0, and PULL_LOW is LOAD_BOTH with direction 1 and value 0.

Top module: `gpio_od_pair_reg`

## Requirements
- R1: While reset is asserted, `rd_data` reads all zero, and `pad_oe` and `pad_out` are 0 on both pins. Both pins are released.
- R2: The direction bit of pin p is `wr_data[8p+1]`. It changes on a write only when the direction strobe `wr_data[8p+0]` is 1. Otherwise it keeps its value.
- R3: The value bit of pin p is `wr_data[8p+3]`. It changes on a write only when the value strobe `wr_data[8p+2]` is 1. Otherwise it keeps its value.
- R4: A write with only the direction strobe set and direction 0 releases the pin (`pad_oe` goes to 0). A following write with no strobes leaves the pin released.
- R5: A write with both strobes set, direction 1 and value 0 makes the pin pull low: after that edge, `pad_oe`=1 and `pad_out`=0.
- R6: The strobe bits (8p+0, 8p+2) and the unused bits (8p+6, 8p+7) always read as 0.
- R7: The read-only bit 8p+4 shows the level of `pad_in[p]` sampled two clock edges earlier.
- R8: The pull-up-disable bit 8p+5 is loaded from `wr_data` on every write, whatever the strobes are, and reads back as written.
- R9: `pad_oe[p]` equals the readable direction bit 8p+1, and `pad_out[p]` equals the readable value bit 8p+3.
- R10: The fields of the two pins are independent. A write changes a pin only through that pin's own strobes. Pin 0 is the clock pin and pin 1 is the data pin.
- R11: While `wr_en` is 0, no stored field changes, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write word, 8 bits per pin |
| rd_data | output | 16 | Read word: stored fields, sampled levels, and zero in the strobe positions |
| pad_in | input | 2 | Raw pad levels (bit 0 clock, bit 1 data) |
| pad_oe | output | 2 | Pad output enable per pin |
| pad_out | output | 2 | Pad output data per pin |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable around the rising edge and that a write lasts exactly one cycle. They also assume that `pad_in` is a raw asynchronous level that only the synchroniser looks at. The bench changes `wr_en`, `wr_data` and `pad_in` only on falling edges, so no input moves at a sampling edge. It mixes directed strobe patterns with random writes, so that every strobe combination, including writes with no strobe set, lands on every one of the four pin states.

// File: rtl/padreg_pkg.sv
package padreg_pkg;

    // Bits per pin slot in the register word.
    localparam int FIELD_W = 8;

    // Pin state: {direction, value}.
    typedef enum logic [1:0] {
        PS_FLOAT_LO = 2'b00,
        PS_FLOAT_HI = 2'b01,
        PS_SINK     = 2'b10,
        PS_SOURCE   = 2'b11
    } pin_state_e;

    // One pin slot, packed from MSB down to bit 0.
    typedef struct packed {
        logic [1:0] rsvd;     // bits 7:6
        logic       pu_dis;   // bit 5
        logic       sampled;  // bit 4 (read-only)
        logic       val;      // bit 3
        logic       val_stb;  // bit 2 (write strobe)
        logic       dir;      // bit 1
        logic       dir_stb;  // bit 0 (write strobe)
    } pin_field_t;

endpackage

// File: rtl/padreg_sync.sv
module padreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] s_q;
    logic              up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q  <= '0;
            up_q <= 1'b0;
        end else begin
            s_q  <= {s_q[STAGES-2:0], din};
            up_q <= 1'b1;
        end
    end

    assign dout = s_q[STAGES-1];

    // R7
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (s_q[0] == $past(din)));

    for (genvar k = 1; k < STAGES; k++) begin : g_stage_chk
        // R7
        sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_q |-> (s_q[k] == $past(s_q[k-1])));
    end
endmodule

// File: rtl/padreg_pin_fsm.sv
module padreg_pin_fsm
    import padreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic dir_stb,
    input  logic dir_d,
    input  logic val_stb,
    input  logic val_d,
    input  logic pu_d,
    output logic oe,
    output logic out,
    output logic pu_dis
);
    pin_state_e state_q, state_nx;
    logic       cur_dir, cur_val;
    logic       pu_q;

    assign cur_dir = state_q[1];
    assign cur_val = state_q[0];

    // Next-state logic: HOLD, LOAD_VAL, LOAD_DIR, LOAD_BOTH.
    always_comb begin
        state_nx = state_q;
        if (wr_en) begin
            unique case ({dir_stb, val_stb})
                2'b00: state_nx = state_q;                           // HOLD
                2'b01: state_nx = pin_state_e'({cur_dir, val_d});    // LOAD_VAL
                2'b10: state_nx = pin_state_e'({dir_d, cur_val});    // LOAD_DIR
                2'b11: state_nx = pin_state_e'({dir_d, val_d});      // LOAD_BOTH
                default: state_nx = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_FLOAT_LO;
        else        state_q <= state_nx;
    end

    // Pull-up-disable bit: a plain bit loaded on every write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pu_q <= 1'b0;
        else if (wr_en) pu_q <= pu_d;
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            PS_FLOAT_LO: begin oe = 1'b0; out = 1'b0; end
            PS_FLOAT_HI: begin oe = 1'b0; out = 1'b1; end
            PS_SINK:     begin oe = 1'b1; out = 1'b0; end
            PS_SOURCE:   begin oe = 1'b1; out = 1'b1; end
            default:     begin oe = 1'b0; out = 1'b0; end
        endcase
    end

    assign pu_dis = pu_q;

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dir_stb) |=> (oe == $past(oe)));
    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dir_stb) |=> (oe == $past(dir_d)));
    // R3
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !val_stb) |=> (out == $past(out)));
    // R3
    val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && val_stb) |=> (out == $past(val_d)));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({oe, out, pu_dis}));
    // R8
    pu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pu_dis == $past(pu_d)));
endmodule

// File: rtl/gpio_od_pair_reg.sv
module gpio_od_pair_reg
    import padreg_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [NUM_PINS*FIELD_W-1:0]   wr_data,
    output logic [NUM_PINS*FIELD_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0]           pad_in,
    output logic [NUM_PINS-1:0]           pad_oe,
    output logic [NUM_PINS-1:0]           pad_out
);
    localparam int REG_W = NUM_PINS * FIELD_W;

    logic [REG_W-1:0] rd_word;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_field_t wf;
        pin_field_t rf;
        logic       oe_w, out_w, pu_w, smp_w;
        logic       unused_bits;

        assign wf          = pin_field_t'(wr_data[p*FIELD_W +: FIELD_W]);
        assign unused_bits = ^{wf.rsvd, wf.sampled};

        padreg_pin_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .dir_stb (wf.dir_stb),
            .dir_d   (wf.dir),
            .val_stb (wf.val_stb),
            .val_d   (wf.val),
            .pu_d    (wf.pu_dis),
            .oe      (oe_w),
            .out     (out_w),
            .pu_dis  (pu_w)
        );

        padreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pad_in[p]),
            .dout  (smp_w)
        );

        always_comb begin
            rf         = '0;
            rf.dir     = oe_w;
            rf.val     = out_w;
            rf.sampled = smp_w;
            rf.pu_dis  = pu_w;
        end

        assign rd_word[p*FIELD_W +: FIELD_W] = rf;
        assign pad_oe[p]  = oe_w;
        assign pad_out[p] = out_w;
    end

    assign rd_data = rd_word;
endmodule

// File: tb/gpio_od_pair_reg_bench.sv
module gpio_od_pair_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  pad_in = '0;
    logic [1:0]  pad_oe, pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int m_dir[2];
    int m_val[2];
    int m_pu[2];
    logic [1:0] hist[$];

    always #2 clk = ~clk;

    gpio_od_pair_reg u_gpio_od_pair_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin m_dir[p] = 0; m_val[p] = 0; m_pu[p] = 0; end
        hist.push_back(2'b00);
        hist.push_back(2'b00);
    end

    // Model update on each rising edge, then compare just after it.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin m_dir[p] = 0; m_val[p] = 0; m_pu[p] = 0; end
            hist.delete();
            hist.push_back(2'b00);
            hist.push_back(2'b00);
        end else begin
            if (wr_en) begin
                for (int p = 0; p < 2; p++) begin
                    if (wr_data[8*p+0]) m_dir[p] = int'(wr_data[8*p+1]);
                    if (wr_data[8*p+2]) m_val[p] = int'(wr_data[8*p+3]);
                    m_pu[p] = int'(wr_data[8*p+5]);
                end
            end
            hist.push_front(pad_in);
            void'(hist.pop_back());
            #1;
            for (int p = 0; p < 2; p++) begin
                chk("R2 direction", pad_oe[p], m_dir[p]);
                chk("R3 value", pad_out[p], m_val[p]);
                chk("R8 pull-up", rd_data[8*p+5], m_pu[p]);
                chk("R7 sampled", rd_data[8*p+4], hist[1][p]);
                chk("R6 strobe/unused", {rd_data[8*p+7], rd_data[8*p+6], rd_data[8*p+2], rd_data[8*p+0]}, 0);
                chk("R9 readback", {rd_data[8*p+3], rd_data[8*p+1]}, {pad_out[p], pad_oe[p]});
            end
        end
    end

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 pad_oe", pad_oe, 2'b00);
        chk("R1 pad_out", pad_out, 2'b00);
        rst_n = 1'b1;

        // R5 pull clock pin low with both strobes
        wr(16'h0007);
        chk("R5 oe", pad_oe[0], 1'b1);
        chk("R5 out", pad_out[0], 1'b0);
        chk("R10 data pin untouched", pad_oe[1], 1'b0);

        // R4 release by direction strobe only, then a plain write
        wr(16'h0001);
        chk("R4 released", pad_oe[0], 1'b0);
        wr(16'h0000);
        chk("R4 stays released", pad_oe[0], 1'b0);

        // R3 value needs its strobe
        wr(16'h000C);
        chk("R3 loaded", pad_out[0], 1'b1);
        wr(16'h0000);
        chk("R3 held", pad_out[0], 1'b1);

        // R8 pull-up bits
        wr(16'h2020);
        chk("R8 set", {rd_data[13], rd_data[5]}, 2'b11);
        wr(16'h0000);
        chk("R8 cleared", {rd_data[13], rd_data[5]}, 2'b00);

        // R10 data pin pulled low, clock pin keeps its state
        wr(16'h0700);
        chk("R10 data oe", pad_oe[1], 1'b1);
        chk("R10 clock unchanged", {pad_oe[0], pad_out[0]}, 2'b01);

        // R11 data present without wr_en
        @(negedge clk);
        wr_data = 16'h0F0F;
        repeat (2) @(negedge clk);
        chk("R11 oe", pad_oe, 2'b10);
        chk("R11 out", pad_out, 2'b01);
        wr_data = '0;

        // R7 two-edge synchroniser lag
        pad_in = 2'b10;
        @(negedge clk);
        chk("R7 after one edge", rd_data[12], 1'b0);
        @(negedge clk);
        chk("R7 after two edges", rd_data[12], 1'b1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_en   = ($urandom % 3) == 0;
            wr_data = 16'($urandom);
            if (($urandom % 4) == 0) pad_in = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end
endmodule